// File: doc/BRIEF.md
# Transmit Fault and Shutdown Controller

This block collects the digital results of the fast fault comparators of a laser transmitter and turns them into a transmit-fault output and a laser shutdown request. Four fault sources are handled:

- high optical power
- low optical power
- high bias current
- bias drive at its ceiling

Each source has its own enable. An enabled source that is active sets the fault output.

Recovery is governed by a reset interval counted on a slow prescaled tick. The default is 130 ticks of a 1 kHz tick, which gives 130 ms. In follow mode the fault clears once the enabled sources have stayed quiet for the whole interval. In hold mode the fault also needs a pulse on the transmit-disable pin before the interval may start. The high-bias status bit is sticky and only the transmit-disable pin clears it. A global mask keeps faults from reaching the shutdown request while the fault output still reports them. The pin level is also returned as a status bit.

Top module: `tx_fault_ctrl`

## Requirements
- R1: After reset, fault_o, status_o and txd_status_o are 0.
- R2: status_o bits 0 (high power), 1 (low power) and 3 (bias at ceiling) take the value of the matching flag_i bit one clock edge later. This holds whatever the enables are.
- R3: status_o bit 2 (high bias) is set one edge after flag_i[2] is high. It stays set after the flag drops. It is cleared on the edge after txd_pin_i is high, and this clear wins over a flag that is set in the same cycle.
- R4: A source whose status bit is set and whose enable_i bit is 1 raises fault_o on the next edge, which is two edges after the flag. A source with its enable bit at 0 never raises fault_o.
- R5: In follow mode (latch_mode_i = 0), fault_o falls on the edge that samples the RESET_TICKS-th tick_i pulse counted while no enabled status bit is set. Any enabled status bit that returns during the count restarts it from zero.
- R6: In hold mode (latch_mode_i = 1), fault_o stays high through any number of ticks until txd_pin_i has been high while the fault was set. After that, recovery follows R5.
- R7: shutdown_o is combinationally txd_pin_i OR sw_disable_i OR (fault_o AND NOT mask_i).
- R8: mask_i has no effect on fault_o or status_o.
- R9: txd_status_o equals txd_pin_i delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse from the prescaler for the reset interval |
| flag_i | input | 4 | Comparator flags: [0] high power, [1] low power, [2] high bias, [3] bias at ceiling |
| enable_i | input | 4 | Per-source enables, same bit order as flag_i |
| txd_pin_i | input | 1 | Transmit-disable pin level |
| sw_disable_i | input | 1 | Software transmit disable |
| latch_mode_i | input | 1 | 1 selects hold mode, 0 selects follow mode |
| mask_i | input | 1 | Keeps faults out of the shutdown request |
| fault_o | output | 1 | Transmit-fault output |
| shutdown_o | output | 1 | Laser shutdown request |
| status_o | output | 4 | Captured fault status, same bit order as flag_i |
| txd_status_o | output | 1 | Registered level of the transmit-disable pin |

## Verification
A flag driven in cycle c is due on status_o in cycle c+1 and on fault_o in cycle c+2. Shutdown caused by the pin or the software bit is due in the first cycle after the drive. A tick driven in cycle d releases the fault in cycle d+1. The scoreboard stores each expectation with its absolute due cycle, and the monitor compares only those entries, at the falling edge of that exact cycle. Inputs change one time step after the falling edge, so each sample sees the settled values of the interval it belongs to.

// File: rtl/tx_fault_pkg.sv
package tx_fault_pkg;
  localparam int unsigned NUM_SRC = 4;
  typedef enum int unsigned {
    SRC_PWR_HI   = 0,
    SRC_PWR_LO   = 1,
    SRC_BIAS_HI  = 2,
    SRC_BIAS_TOP = 3
  } fault_src_e;
  localparam int unsigned STICKY_SRC = SRC_BIAS_HI;
endpackage

// File: rtl/fault_flag_capture.sv
module fault_flag_capture #(
  parameter int unsigned NUM_SRC    = tx_fault_pkg::NUM_SRC,
  parameter int unsigned STICKY_SRC = tx_fault_pkg::STICKY_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == STICKY_SRC) begin : g_sticky
      // clear has priority over a new flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    status_o[i] <= 1'b0;
        else if (clr_i) status_o[i] <= 1'b0;
        else            status_o[i] <= status_o[i] | flag_i[i];
      end

      a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !status_o[i]);
      a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[i] && !clr_i) |=> status_o[i]);
    end else begin : g_mirror
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_o[i] <= 1'b0;
        else         status_o[i] <= flag_i[i];
      end

      a_r2_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_i[i] |=> status_o[i]);
    end
  end
endmodule

// File: rtl/fault_recovery.sv
module fault_recovery #(
  parameter int unsigned RESET_TICKS = 130
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic tick_i,
  input  logic clr_req_i,
  input  logic latch_mode_i,
  output logic fault_o
);
  localparam int unsigned CNT_W = $clog2(RESET_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESET_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             release_ok;

  // hold mode waits for a disable pulse before the interval may run
  assign release_ok = !latch_mode_i || armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (det_i) begin
      fault_o <= 1'b1;
      cnt_q   <= '0;
      if (clr_req_i && fault_o) armed_q <= 1'b1;
    end else if (fault_o) begin
      if (clr_req_i) armed_q <= 1'b1;
      if (release_ok && tick_i) begin
        if (cnt_q == CNT_LAST) begin
          fault_o <= 1'b0;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r4_fault_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_i |=> fault_o);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(RESET_TICKS));
  a_r5_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !tick_i) |=> fault_o);
  a_r6_hold_until_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && latch_mode_i && !armed_q) |=> fault_o);
endmodule

// File: rtl/tx_fault_ctrl.sv
module tx_fault_ctrl #(
  parameter int unsigned NUM_SRC     = tx_fault_pkg::NUM_SRC,
  parameter int unsigned RESET_TICKS = 130
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic               txd_pin_i,
  input  logic               sw_disable_i,
  input  logic               latch_mode_i,
  input  logic               mask_i,
  output logic               fault_o,
  output logic               shutdown_o,
  output logic [NUM_SRC-1:0] status_o,
  output logic               txd_status_o
);
  logic det;

  fault_flag_capture #(
    .NUM_SRC    (NUM_SRC),
    .STICKY_SRC (tx_fault_pkg::STICKY_SRC)
  ) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_i   (flag_i),
    .clr_i    (txd_pin_i),
    .status_o (status_o)
  );

  assign det = |(status_o & enable_i);

  fault_recovery #(
    .RESET_TICKS (RESET_TICKS)
  ) i_recovery (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .det_i        (det),
    .tick_i       (tick_i),
    .clr_req_i    (txd_pin_i),
    .latch_mode_i (latch_mode_i),
    .fault_o      (fault_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txd_status_o <= 1'b0;
    else         txd_status_o <= txd_pin_i;
  end

  assign shutdown_o = txd_pin_i | sw_disable_i | (fault_o & ~mask_i);

  a_r7_disable_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_pin_i || sw_disable_i) |-> shutdown_o);
  a_r8_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && !txd_pin_i && !sw_disable_i) |-> !shutdown_o);
  a_r9_pin_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_pin_i |=> txd_status_o);
endmodule

// File: tb/test_tx_fault_ctrl.sv
module test_tx_fault_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RT         = 4;
  localparam int SIG_FAULT = 0, SIG_SHUT = 1, SIG_STAT = 2, SIG_TXDS = 3;

  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic [3:0] flag = '0, en = '0;
  logic       txd = 1'b0, sw = 1'b0, latch = 1'b0, mask = 1'b0;
  logic       fault, shut, txds;
  logic [3:0] stat;

  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int         due;
    int         sig;
    logic [3:0] val;
    string      req;
  } exp_t;
  exp_t q[$];

  tx_fault_ctrl #(.RESET_TICKS(RT)) i_tx_fault_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .flag_i(flag), .enable_i(en),
    .txd_pin_i(txd), .sw_disable_i(sw), .latch_mode_i(latch), .mask_i(mask),
    .fault_o(fault), .shutdown_o(shut), .status_o(stat), .txd_status_o(txds));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expectation due in this interval
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [3:0] act;
        case (q[i].sig)
          SIG_FAULT: act = {3'b0, fault};
          SIG_SHUT:  act = {3'b0, shut};
          SIG_STAT:  act = stat;
          default:   act = {3'b0, txds};
        endcase
        n_run++;
        if (act !== q[i].val) begin
          n_fail++;
          $display("FAIL %s sig%0d cycle %0d: actual %b expected %b",
                   q[i].req, q[i].sig, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_at(int dly, int sig, logic [3:0] v, string r);
    q.push_back('{cyc + dly, sig, v, r});
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic tick_pulse();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic release_check(string r);
    for (int i = 0; i < RT - 1; i++) tick_pulse();
    expect_at(1, SIG_FAULT, 4'd1, r);
    step();
    expect_at(1, SIG_FAULT, 4'd0, r);
    tick_pulse();
    steps(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    steps(3);
    rst_ni = 1'b1;
    expect_at(1, SIG_FAULT, 4'd0, "R1");
    expect_at(1, SIG_STAT, 4'd0, "R1");
    expect_at(1, SIG_TXDS, 4'd0, "R1");
    expect_at(1, SIG_SHUT, 4'd0, "R7");
    steps(2);
    en = 4'hF;

    // R2 R4 R5: follow-mode fault and release
    flag = 4'b0001;
    expect_at(1, SIG_STAT, 4'b0001, "R2");
    expect_at(1, SIG_FAULT, 4'd0, "R4");
    expect_at(2, SIG_FAULT, 4'd1, "R4");
    expect_at(2, SIG_SHUT, 4'd1, "R7");
    steps(3);
    flag = 4'b0;
    expect_at(1, SIG_STAT, 4'b0, "R2");
    steps(3);
    release_check("R5");

    // R4: disabled source
    en = 4'b1101;
    flag = 4'b0010;
    expect_at(1, SIG_STAT, 4'b0010, "R2");
    expect_at(2, SIG_FAULT, 4'd0, "R4");
    expect_at(2, SIG_SHUT, 4'd0, "R7");
    steps(3);
    flag = 4'b0;
    en = 4'hF;
    steps(2);

    // R6: hold mode
    latch = 1'b1;
    flag = 4'b1000;
    expect_at(1, SIG_STAT, 4'b1000, "R2");
    expect_at(2, SIG_FAULT, 4'd1, "R6");
    steps(2);
    flag = 4'b0;
    steps(3);
    for (int i = 0; i < RT + 2; i++) tick_pulse();
    expect_at(1, SIG_FAULT, 4'd1, "R6");
    step();
    txd = 1'b1;
    expect_at(1, SIG_SHUT, 4'd1, "R7");
    expect_at(1, SIG_TXDS, 4'd1, "R9");
    step();
    txd = 1'b0;
    expect_at(1, SIG_TXDS, 4'd0, "R9");
    steps(2);
    release_check("R6");
    latch = 1'b0;

    // R3: sticky high-bias bit
    flag = 4'b0100;
    expect_at(1, SIG_STAT, 4'b0100, "R3");
    expect_at(2, SIG_FAULT, 4'd1, "R4");
    step();
    flag = 4'b0;
    steps(3);
    expect_at(1, SIG_STAT, 4'b0100, "R3");
    step();
    for (int i = 0; i < RT + 1; i++) tick_pulse();
    expect_at(1, SIG_FAULT, 4'd1, "R3");
    step();
    txd = 1'b1;
    flag = 4'b0100;
    expect_at(1, SIG_STAT, 4'b0, "R3");
    step();
    txd = 1'b0;
    flag = 4'b0;
    expect_at(1, SIG_STAT, 4'b0, "R3");
    steps(2);
    release_check("R5");

    // R8 R7: mask and software disable
    mask = 1'b1;
    flag = 4'b0001;
    expect_at(2, SIG_FAULT, 4'd1, "R8");
    expect_at(2, SIG_SHUT, 4'd0, "R8");
    expect_at(2, SIG_STAT, 4'b0001, "R8");
    steps(3);
    sw = 1'b1;
    expect_at(1, SIG_SHUT, 4'd1, "R7");
    step();
    sw = 1'b0;
    expect_at(1, SIG_SHUT, 4'd0, "R7");
    step();
    flag = 4'b0;
    mask = 1'b0;
    expect_at(1, SIG_SHUT, 4'd1, "R7");
    steps(3);
    release_check("R5");

    // R5: returning source restarts the count
    flag = 4'b0001;
    steps(3);
    flag = 4'b0;
    steps(3);
    tick_pulse();
    tick_pulse();
    flag = 4'b0001;
    steps(3);
    flag = 4'b0;
    steps(3);
    release_check("R5");

    steps(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule